// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests for a small processor core from seven sources in a fixed order of precedence: a startup request, three external request pins (one dedicated, two sharing a slot with the second serial port), transmit and receive events of two serial ports, and a timer. Each request is gated by a mask register. The highest-ranked survivor is presented to the core as a request strobe and a vector address. The startup request cannot be masked.

When the core accepts the request, the controller saves the core's arithmetic status, its mode status and the current mask on an internal stack seven entries deep. On a return from interrupt it restores them. A control register picks edge or level sensing for each external pin and selects nested or one-at-a-time servicing. Software can force or clear any pending request through a write-only force/clear port.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Source rank, highest first: 0 startup, 1 ext pin 2, 2 port0 TX, 3 port0 RX, 4 port1 TX or ext pin 1, 5 port1 RX or ext pin 0, 6 timer. `vec_o` equals 4 times the index of the selected source (0x00..0x18). The lowest eligible index wins.
- R2: Source 0 is issued whatever the mask holds. Any other source is issued only while its `mask_o` bit (bit index = source index) is 1.
- R3: `ctrl` bit 0, 1 and 2 set ext pins 0, 1 and 2 (all active low) to edge mode when 1. In edge mode a falling edge latches a pending bit, which stays after the pin returns high. In level mode the request follows the pin low level and is not latched. A one-cycle pulse on `reset_req_i` or `periph_req_i` latches a pending bit.
- R4: With `ctrl` bit 4 = 1 (nested), while a service is active only sources of strictly higher rank are issued. With bit 4 = 0 (sequential), nothing is issued while a service is active. Source 0 is exempt from both rules. Held requests are issued after the return.
- R5: With `ifc_we_i`, a 1 in `ifc_force_i` sets that pending bit and a 1 in `ifc_clear_i` clears it. Clear wins on the same bit. Neither changes the mask.
- R6: `ack_i` while `irq_o` is 1 pushes {astat, mstat, mask}, raises `depth_o` by one and clears the taken source's pending bit.
- R7: `rti_i` with a non-empty stack pops the top entry. In the next cycle `restore_o` is 1, `astat_o`/`mstat_o` carry the saved words, `mask_o` holds the saved mask, and `depth_o` has dropped by one.
- R8: An acknowledge with seven entries stored drops the push and sets `stack_ovf_o`, which stays set until reset. `rti_i` with an empty stack changes nothing and gives no `restore_o`.
- R9: After reset `irq_o`, `depth_o`, `stack_ovf_o` and `mask_o` are 0.
- R10: `ack_i` while `irq_o` is 0 has no effect on the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reset_req_i | input | 1 | Startup request pulse (source 0) |
| irq_n_i | input | 3 | External pins 0..2, active low |
| periph_req_i | input | 5 | Pulses: p0 TX, p0 RX, p1 TX, p1 RX, timer |
| mask_we_i | input | 1 | Mask write strobe |
| mask_d_i | input | 7 | Mask write data |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_d_i | input | 5 | Control data: bits 2:0 edge select, bit 4 nesting |
| ifc_we_i | input | 1 | Force/clear strobe |
| ifc_force_i | input | 7 | Per-source force bits |
| ifc_clear_i | input | 7 | Per-source clear bits |
| astat_i | input | 8 | Core arithmetic status to save |
| mstat_i | input | 7 | Core mode status to save |
| ack_i | input | 1 | Core accepts the request |
| rti_i | input | 1 | Return from interrupt |
| irq_o | output | 1 | Request to the core |
| vec_o | output | 14 | Vector address |
| restore_o | output | 1 | Restored status valid pulse |
| astat_o | output | 8 | Restored arithmetic status |
| mstat_o | output | 7 | Restored mode status |
| mask_o | output | 7 | Current mask |
| depth_o | output | 3 | Stack entries in use |
| stack_ovf_o | output | 1 | Sticky stack overflow |

## Verification
The assertions check on every cycle that any issued non-startup vector is unmasked and that vectors are aligned and in range. They also check that servicing mode limits what may be issued while a handler runs, that an accepted request grows the stack by one, and that the overflow flag is sticky and an empty pop does nothing. Several behaviours can only be shown by the bench scenarios: the ranking among simultaneous requests, the exact restored words and mask after each return, edge latching against level following, clear beating force, and held requests being released after a return.

// File: rtl/irq_vc_pkg.sv
package irq_vc_pkg;
  localparam int NSRC      = 7;
  localparam int NEXT      = 3;
  localparam int NPER      = 5;
  localparam int LVL_W     = $clog2(NSRC + 1);
  localparam logic [LVL_W-1:0] LVL_NONE = LVL_W'(NSRC);
  localparam int VEC_W     = 14;
  localparam int VEC_STEP  = 4;
  localparam int ASTAT_W   = 8;
  localparam int MSTAT_W   = 7;
  localparam int CTRL_W    = 5;
  localparam int NEST_BIT  = 4;
  localparam int STK_DEPTH = 7;
  localparam int DEPTH_W   = $clog2(STK_DEPTH + 1);

  typedef struct packed {
    logic [ASTAT_W-1:0] astat;
    logic [MSTAT_W-1:0] mstat;
    logic [NSRC-1:0]    mask;
    logic [LVL_W-1:0]   lvl;
  } frame_t;

  localparam int FRAME_W = $bits(frame_t);

  // external pin feeding a source, -1 if none
  function automatic int ext_of(input int s);
    case (s)
      1:       return 2;
      4:       return 1;
      5:       return 0;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/irq_vc_req.sv
module irq_vc_req
  import irq_vc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] int_req_i,
  input  logic [NEXT-1:0] irq_n_i,
  input  logic [NEXT-1:0] edge_i,
  input  logic [NSRC-1:0] force_i,
  input  logic [NSRC-1:0] clear_i,
  input  logic [NSRC-1:0] ack_clr_i,
  output logic [NSRC-1:0] req_o
);
  logic [NEXT-1:0] irq_n_q;
  logic [NEXT-1:0] fall;
  logic [NSRC-1:0] set, lvl, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_n_q <= '1;
    else         irq_n_q <= irq_n_i;
  end

  assign fall = irq_n_q & ~irq_n_i & edge_i;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    if (ext_of(s) >= 0) begin : g_ext
      localparam int E = ext_of(s);
      assign set[s] = int_req_i[s] | force_i[s] | fall[E];
      assign lvl[s] = ~edge_i[E] & ~irq_n_i[E];
    end else begin : g_int
      assign set[s] = int_req_i[s] | force_i[s];
      assign lvl[s] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q | set) & ~(clear_i | ack_clr_i);
  end

  assign req_o = pend_q | lvl;
endmodule

// File: rtl/irq_vc_sel.sv
module irq_vc_sel
  import irq_vc_pkg::*;
(
  input  logic [NSRC-1:0]  req_i,
  input  logic [NSRC-1:0]  mask_i,
  input  logic             nest_i,
  input  logic [LVL_W-1:0] active_i,
  output logic             valid_o,
  output logic [LVL_W-1:0] idx_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [NSRC-1:0] elig;

  for (genvar s = 0; s < NSRC; s++) begin : g_elig
    if (s == 0) begin : g_top
      assign elig[s] = req_i[s];
    end else begin : g_rest
      assign elig[s] = req_i[s] & mask_i[s] &
                       (nest_i ? (LVL_W'(s) < active_i) : (active_i == LVL_NONE));
    end
  end

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (elig[s]) begin
        valid_o = 1'b1;
        idx_o   = LVL_W'(s);
      end
    end
  end

  assign vec_o = VEC_W'(idx_o) * VEC_W'(VEC_STEP);
endmodule

// File: rtl/irq_vc_stack.sv
module irq_vc_stack #(
  parameter int DEPTH = 7,
  parameter int W     = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [W-1:0]     din_i,
  output logic [W-1:0]     dout_o,
  output logic [CNT_W-1:0] depth_o,
  output logic             ovf_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic             full, empty, do_pop, do_push;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_pop  = pop_i & ~empty;
  assign do_push = push_i & ~pop_i & ~full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (do_pop)       cnt_q <= cnt_q - 1'b1;
      else if (do_push) cnt_q <= cnt_q + 1'b1;
      if (push_i && !pop_i && full) ovf_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[PTR_W'(cnt_q)] <= din_i;
  end

  assign dout_o  = empty ? '0 : mem[PTR_W'(cnt_q - 1'b1)];
  assign depth_o = cnt_q;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reset_req_i,
  input  logic [NEXT-1:0]    irq_n_i,
  input  logic [NPER-1:0]    periph_req_i,
  input  logic               mask_we_i,
  input  logic [NSRC-1:0]    mask_d_i,
  input  logic               ctrl_we_i,
  input  logic [CTRL_W-1:0]  ctrl_d_i,
  input  logic               ifc_we_i,
  input  logic [NSRC-1:0]    ifc_force_i,
  input  logic [NSRC-1:0]    ifc_clear_i,
  input  logic [ASTAT_W-1:0] astat_i,
  input  logic [MSTAT_W-1:0] mstat_i,
  input  logic               ack_i,
  input  logic               rti_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               restore_o,
  output logic [ASTAT_W-1:0] astat_o,
  output logic [MSTAT_W-1:0] mstat_o,
  output logic [NSRC-1:0]    mask_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               stack_ovf_o
);
  logic [NSRC-1:0]   mask_q, req, ack_clr, int_req, frc, clr;
  logic [CTRL_W-1:0] ctrl_q;
  logic [LVL_W-1:0]  active_q, sel_idx;
  logic              take, do_pop;
  frame_t            push_f, top_f;
  logic [FRAME_W-1:0] top_raw;

  assign int_req = {periph_req_i, 1'b0, reset_req_i};
  assign frc     = ifc_we_i ? ifc_force_i : '0;
  assign clr     = ifc_we_i ? ifc_clear_i : '0;
  assign take    = ack_i & irq_o & ~rti_i;
  assign do_pop  = rti_i & (depth_o != '0);
  assign ack_clr = take ? (NSRC'(1) << sel_idx) : '0;

  irq_vc_req u_req (
    .clk_i, .rst_ni,
    .int_req_i (int_req),
    .irq_n_i,
    .edge_i    (ctrl_q[NEXT-1:0]),
    .force_i   (frc),
    .clear_i   (clr),
    .ack_clr_i (ack_clr),
    .req_o     (req)
  );

  irq_vc_sel u_sel (
    .req_i    (req),
    .mask_i   (mask_q),
    .nest_i   (ctrl_q[NEST_BIT]),
    .active_i (active_q),
    .valid_o  (irq_o),
    .idx_o    (sel_idx),
    .vec_o
  );

  assign push_f = '{astat: astat_i, mstat: mstat_i, mask: mask_q, lvl: active_q};

  irq_vc_stack #(.DEPTH(STK_DEPTH), .W(FRAME_W)) u_stk (
    .clk_i, .rst_ni,
    .push_i  (take),
    .pop_i   (rti_i),
    .din_i   (push_f),
    .dout_o  (top_raw),
    .depth_o,
    .ovf_o   (stack_ovf_o)
  );

  assign top_f = frame_t'(top_raw);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= '0;
      ctrl_q    <= '0;
      active_q  <= LVL_NONE;
      restore_o <= 1'b0;
      astat_o   <= '0;
      mstat_o   <= '0;
    end else begin
      restore_o <= do_pop;
      if (ctrl_we_i) ctrl_q <= ctrl_d_i;
      if (do_pop)         mask_q <= top_f.mask;
      else if (mask_we_i) mask_q <= mask_d_i;
      if (take)        active_q <= sel_idx;
      else if (do_pop) active_q <= top_f.lvl;
      if (do_pop) begin
        astat_o <= top_f.astat;
        mstat_o <= top_f.mstat;
      end
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_vc_chk.sv
module irq_vc_chk
  import irq_vc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ack_i,
  input logic               rti_i,
  input logic               irq_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic [NSRC-1:0]    mask_o,
  input logic [DEPTH_W-1:0] depth_o,
  input logic               stack_ovf_o,
  input logic               restore_o,
  input logic               nest_i,
  input logic [LVL_W-1:0]   active_i
);
  logic [LVL_W-1:0] vidx;
  assign vidx = vec_o[2 +: LVL_W];

  AST_VEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o[1:0] == 2'b00 && vec_o <= VEC_W'((NSRC - 1) * VEC_STEP))); // R1
  AST_IRQ_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && vidx != '0) |-> mask_o[vidx]); // R2
  AST_SEQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nest_i && active_i != LVL_NONE && irq_o) |-> vidx == '0); // R4
  AST_NEST_HIGHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nest_i && irq_o) |-> (vidx < active_i || vidx == '0)); // R4
  AST_PUSH_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !rti_i && depth_o < DEPTH_W'(STK_DEPTH)) |=> depth_o == $past(depth_o) + 1'b1); // R6
  AST_POP_RESTORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rti_i && depth_o != '0) |=> restore_o); // R7
  AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_ovf_o |=> stack_ovf_o); // R8
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rti_i && depth_o == '0) |=> (depth_o == '0 && !restore_o)); // R8
  AST_IDLE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !rti_i) |=> $stable(depth_o)); // R10
endmodule

bind irq_vector_ctrl irq_vc_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ack_i       (ack_i),
  .rti_i       (rti_i),
  .irq_o       (irq_o),
  .vec_o       (vec_o),
  .mask_o      (mask_o),
  .depth_o     (depth_o),
  .stack_ovf_o (stack_ovf_o),
  .restore_o   (restore_o),
  .nest_i      (ctrl_q[irq_vc_pkg::NEST_BIT]),
  .active_i    (active_q)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic reset_req = 0, mask_we = 0, ctrl_we = 0, ifc_we = 0, ack = 0, rti = 0;
  logic [2:0] irq_n = '1;
  logic [4:0] periph = '0;
  logic [6:0] mask_d = '0, ifc_f = '0, ifc_c = '0;
  logic [4:0] ctrl_d = '0;
  logic [7:0] astat = '0;
  logic [6:0] mstat = '0;
  logic irq, restore, ovf;
  logic [13:0] vec;
  logic [7:0] astat_o;
  logic [6:0] mstat_o, mask_o;
  logic [2:0] depth;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  irq_vector_ctrl dut (
    .clk_i(clk), .rst_ni, .reset_req_i(reset_req), .irq_n_i(irq_n),
    .periph_req_i(periph), .mask_we_i(mask_we), .mask_d_i(mask_d),
    .ctrl_we_i(ctrl_we), .ctrl_d_i(ctrl_d), .ifc_we_i(ifc_we),
    .ifc_force_i(ifc_f), .ifc_clear_i(ifc_c), .astat_i(astat), .mstat_i(mstat),
    .ack_i(ack), .rti_i(rti), .irq_o(irq), .vec_o(vec), .restore_o(restore),
    .astat_o, .mstat_o, .mask_o, .depth_o(depth), .stack_ovf_o(ovf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic wr_mask(input logic [6:0] m); mask_d = m; mask_we = 1; step(); mask_we = 0; endtask
  task automatic wr_ctrl(input logic [4:0] c); ctrl_d = c; ctrl_we = 1; step(); ctrl_we = 0; endtask
  task automatic ifc(input logic [6:0] f, input logic [6:0] c);
    ifc_f = f; ifc_c = c; ifc_we = 1; step(); ifc_we = 0; ifc_f = '0; ifc_c = '0;
  endtask
  task automatic do_ack(input logic [7:0] a, input logic [6:0] m);
    astat = a; mstat = m; ack = 1; step(); ack = 0;
  endtask
  task automatic do_rti(); rti = 1; step(); rti = 0; endtask

  task automatic t_reset();
    chk("R9 irq", irq, 0); chk("R9 depth", depth, 0);
    chk("R9 ovf", ovf, 0); chk("R9 mask", mask_o, 0);
  endtask

  task automatic t_mask();
    ifc(7'h08, 0);
    chk("R2 masked src3", irq, 0);
    reset_req = 1; step(); reset_req = 0;
    chk("R2 startup unmaskable irq", irq, 1); chk("R2 startup vec", vec, 0);
    do_ack(8'h01, 7'h01); chk("R6 depth after startup ack", depth, 1);
    chk("R6 startup pending cleared", irq, 0);
    do_rti(); chk("R7 depth back", depth, 0);
    wr_mask(7'h08); chk("R2 unmasked src3 vec", vec, 14'h0C);
    ifc(0, 7'h7F); chk("R5 cleared", irq, 0);
  endtask

  task automatic t_priority();
    wr_mask(7'h7E);
    ifc(7'h70, 0); chk("R1 vec src4", vec, 14'h10);
    ifc(0, 7'h10); chk("R1 vec src5", vec, 14'h14);
    ifc(0, 7'h20); chk("R1 vec src6", vec, 14'h18);
    ifc(7'h06, 0); chk("R1 vec src1", vec, 14'h04);
    ifc(0, 7'h7F); chk("R1 none", irq, 0);
  endtask

  task automatic t_edge_level();
    wr_ctrl(5'h04);
    irq_n[2] = 0; step(); chk("R3 edge latched", vec, 14'h04); chk("R3 edge irq", irq, 1);
    irq_n[2] = 1; step(); chk("R3 edge held", irq, 1);
    ifc(0, 7'h02); chk("R3 edge cleared", irq, 0);
    wr_ctrl(5'h00);
    irq_n[2] = 0; step(); chk("R3 level follows", vec, 14'h04); chk("R3 level irq", irq, 1);
    irq_n[2] = 1; step(); chk("R3 level not latched", irq, 0);
    periph[1] = 1; step(); periph[1] = 0; step();
    chk("R3 periph pulse latched", vec, 14'h0C);
    ifc(0, 7'h7F);
  endtask

  task automatic t_force_clear();
    ifc(7'h08, 7'h08);
    chk("R5 clear beats force", irq, 0); chk("R5 mask untouched", mask_o, 7'h7E);
  endtask

  task automatic t_idle_ack();
    do_ack(8'hFF, 7'h7F); chk("R10 idle ack depth", depth, 0);
  endtask

  task automatic t_stack();
    wr_ctrl(5'h10);
    ifc(7'h40, 0); chk("R1 timer vec", vec, 14'h18);
    do_ack(8'hA5, 7'h33); chk("R6 depth1", depth, 1); chk("R6 pending cleared", irq, 0);
    wr_mask(7'h02);
    ifc(7'h02, 0); chk("R4 nested preempt vec", vec, 14'h04);
    do_ack(8'h5A, 7'h11); chk("R6 depth2", depth, 2);
    do_rti();
    chk("R7 restore pulse", restore, 1); chk("R7 astat 1", astat_o, 8'h5A);
    chk("R7 mstat 1", mstat_o, 7'h11); chk("R7 mask 1", mask_o, 7'h02);
    chk("R7 depth1", depth, 1);
    do_rti();
    chk("R7 astat 2", astat_o, 8'hA5); chk("R7 mstat 2", mstat_o, 7'h33);
    chk("R7 mask 2", mask_o, 7'h7E); chk("R7 depth0", depth, 0);
    step(); chk("R7 pulse ends", restore, 0);
  endtask

  task automatic t_nest_seq();
    ifc(7'h08, 0); do_ack(8'h00, 7'h00);
    ifc(7'h20, 0); chk("R4 lower held", irq, 0);
    ifc(7'h08, 0); chk("R4 equal held", irq, 0);
    ifc(7'h04, 0); chk("R4 higher issued", vec, 14'h08);
    ifc(0, 7'h7F); do_rti(); chk("R7 depth after nest", depth, 0);
    wr_ctrl(5'h00);
    ifc(7'h40, 0); do_ack(8'h00, 7'h00);
    ifc(7'h02, 0); chk("R4 sequential holds", irq, 0);
    do_rti(); chk("R4 released after return", vec, 14'h04);
    chk("R4 released irq", irq, 1);
    ifc(0, 7'h7F);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 8; i++) begin
      ifc(7'h01, 0); do_ack(8'(i), 7'(i));
      if (i == 6) begin chk("R8 full depth", depth, 7); chk("R8 no ovf yet", ovf, 0); end
    end
    chk("R8 depth capped", depth, 7); chk("R8 ovf set", ovf, 1);
    for (int i = 0; i < 7; i++) do_rti();
    chk("R8 depth drained", depth, 0); chk("R8 ovf sticky", ovf, 1);
    do_rti(); chk("R8 empty pop depth", depth, 0); chk("R8 empty pop no restore", restore, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_ni = 1; step();
    t_reset();
    t_mask();
    t_priority();
    t_edge_level();
    t_force_clear();
    t_idle_ack();
    t_stack();
    t_nest_seq();
    t_overflow();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule